// File: doc/BRIEF.md
# LPC Memory Cycle Header Decoder

This block is the target-side front end of a Low Pin Count bus peripheral. It samples the active-low frame strobe and the 4-bit LAD bus on every clock. It picks out the start nibble and checks the cycle-type and direction nibble. It then collects the memory address, which arrives over eight clocks. Once that address is complete, the block decides whether the cycle is meant for this device and whether the access goes to the storage array or to the register space.

A cycle that passes every check produces a one-clock request pulse. The pulse carries the direction, the low 24 address bits and the array/register flag. The turnaround, sync and data phases are handled by logic downstream of this block, which consumes that pulse. The block never drives LAD during the header, so its output enable is held off. A standby flag reports when no header is being decoded.

Top module: `lpc_hdr_decode`

## Requirements
- R1: After reset, `req_valid` is 0, `standby` is 1 and `lad_oe` is 0.
- R2: The start nibble is the LAD value on the last clock that `frame_n` is sampled low. Only the value 0000b leads on to a memory-cycle decode; any other start value produces no request.
- R3: The nibble on the first clock with `frame_n` high after the start is the cycle type. Bits [3:2] must be 01b. Bit 1 sets `req_write` (0 = read, 1 = write). Bit 0 has no effect on the outcome.
- R4: When cycle-type bits [3:2] differ from 01b, no request is issued. `standby` reads 1 from the clock after that nibble is sampled.
- R5: The next eight nibbles form a 32-bit address, most significant nibble first. `req_addr` equals address bits 23..0, and bits 31..24 have no effect.
- R6: `req_array` equals address bit 23: 1 selects the array, 0 selects the register space.
- R7: A request is issued only when address bits 22..19 equal the bitwise inverse of `strap_id`, with `strap_id[3]` compared against bit 22. On a mismatch, no request is issued.
- R8: `req_valid` is a single-clock pulse. It appears in the clock after the eighth address nibble is sampled.
- R9: Sampling `frame_n` low at any point after the start abandons the header in progress. A new start is then evaluated and can lead to a normal request.
- R10: `lad_oe` stays 0 at all times.
- R11: `standby` is 0 from the clock after `frame_n` is sampled low until the header decode ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Multiplexed LAD bus as seen by the target |
| strap_id | input | 4 | Device identity strap pins |
| req_valid | output | 1 | One-clock request pulse for a selected memory cycle |
| req_write | output | 1 | Direction of the request, 1 = write |
| req_addr | output | 24 | Local address bits 23..0 |
| req_array | output | 1 | 1 = array access, 0 = register access |
| standby | output | 1 | No header decode in progress |
| lad_oe | output | 1 | LAD output enable, held off |

## Verification
The identity check assumes that `strap_id` stays stable for the whole length of a header. The bench changes the strap only while `frame_n` is high and the decoder is idle. The abort and pulse properties assume that a new cycle cannot complete its header in fewer than ten clocks. The stimulus drives every header through a complete start, cycle-type and eight-nibble sequence, or breaks it off with a fresh start, and never overlaps two headers.

// File: rtl/lpc_hdr_decode.sv
module lpc_hdr_decode #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 8,
  parameter int LOC_W     = 24,
  parameter int ID_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] lad_in,
  input  logic [ID_W-1:0]  strap_id,
  output logic             req_valid,
  output logic             req_write,
  output logic [LOC_W-1:0] req_addr,
  output logic             req_array,
  output logic             standby,
  output logic             lad_oe
);
  localparam int CNT_W = $clog2(ADDR_NIBS);
  localparam int SH_W  = LOC_W - NIB_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_NIBS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_ADDR} state_t;

  state_t           st;
  logic             start_ok;
  logic             dir;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  shreg;
  logic [LOC_W-1:0] full;
  logic             id_hit;

  assign full    = {shreg, lad_in};
  assign id_hit  = full[LOC_W-2 -: ID_W] == ~strap_id;
  assign standby = (st == S_IDLE);
  assign lad_oe  = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      start_ok  <= 1'b0;
      dir       <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_array <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      if (!frame_n) begin
        st       <= S_START;
        start_ok <= (lad_in == '0);
      end else begin
        case (st)
          S_START: begin
            if (start_ok && lad_in[3:2] == 2'b01) begin
              st  <= S_ADDR;
              dir <= lad_in[1];
              cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
          S_ADDR: begin
            shreg <= full[SH_W-1:0];
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
              st <= S_IDLE;
              if (id_hit) begin
                req_valid <= 1'b1;
                req_write <= dir;
                req_addr  <= full;
                req_array <= full[LOC_W-1];
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module lpc_hdr_decode_chk #(
  parameter int LOC_W = 24,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic [ID_W-1:0]  strap_id,
  input logic             req_valid,
  input logic [LOC_W-1:0] req_addr,
  input logic             req_array,
  input logic             standby
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> !req_valid); // R8
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> req_addr[LOC_W-2 -: ID_W] == ~strap_id); // R7
  AST_ARRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> req_array == req_addr[LOC_W-1]); // R6
  AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n) !frame_n |=> !req_valid); // R9
  AST_BUSY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !frame_n |=> !standby); // R11
endmodule

bind lpc_hdr_decode lpc_hdr_decode_chk #(.LOC_W(LOC_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .strap_id(strap_id),
  .req_valid(req_valid), .req_addr(req_addr), .req_array(req_array), .standby(standby)
);

// File: tb/tb_lpc_hdr_decode.sv
module tb_lpc_hdr_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  strap_id = 4'hA;
  logic        req_valid, req_write, req_array, standby, lad_oe;
  logic [23:0] req_addr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lpc_hdr_decode dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in), .strap_id(strap_id),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_array(req_array), .standby(standby), .lad_oe(lad_oe)
  );

  // {start, cycle type, address, strap, exp valid, exp write, exp array}
  localparam logic [46:0] VEC [9] = '{
    {4'h0, 4'h4, 32'hFFA81234, 4'hA, 1'b1, 1'b0, 1'b1},
    {4'h0, 4'h7, 32'h00281ABC, 4'hA, 1'b1, 1'b1, 1'b0},
    {4'h0, 4'h6, 32'h12A8FFFF, 4'hA, 1'b1, 1'b1, 1'b1},
    {4'h0, 4'h4, 32'h00A00000, 4'hA, 1'b0, 1'b0, 1'b0},
    {4'h2, 4'h4, 32'h00A80000, 4'hA, 1'b0, 1'b0, 1'b0},
    {4'h0, 4'h0, 32'h00A80000, 4'hA, 1'b0, 1'b0, 1'b0},
    {4'h0, 4'h8, 32'h00A80000, 4'hA, 1'b0, 1'b0, 1'b0},
    {4'h0, 4'h5, 32'h55800001, 4'hF, 1'b1, 1'b0, 1'b1},
    {4'h0, 4'h4, 32'h007FFFFF, 4'h0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_nibbles(input logic [31:0] a);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      lad_in = a[31-4*i -: 4];
    end
    @(negedge clk);
    lad_in = 4'hF;
  endtask

  task automatic drive_hdr(input bit extra, input logic [3:0] pre, input logic [3:0] st,
                           input logic [3:0] ct, input logic [31:0] a);
    if (extra) begin
      @(negedge clk);
      frame_n = 1'b0; lad_in = pre;
    end
    @(negedge clk);
    frame_n = 1'b0; lad_in = st;
    @(negedge clk);
    frame_n = 1'b1; lad_in = ct;
    send_nibbles(a);
  endtask

  task automatic check_pulse(input string tag, input bit ev, input bit ew, input bit ea,
                             input logic [31:0] a);
    chk({tag, " R7 R2 R4 pulse"}, 32'(req_valid), 32'(ev));
    if (ev) begin
      chk({tag, " R5 addr"}, 32'(req_addr), {8'h0, a[23:0]});
      chk({tag, " R3 dir"}, 32'(req_write), 32'(ew));
      chk({tag, " R6 array"}, 32'(req_array), 32'(ea));
    end
    chk({tag, " R10 oe"}, 32'(lad_oe), 32'h0);
    @(negedge clk);
    chk({tag, " R8 single pulse"}, 32'(req_valid), 32'h0);
    chk({tag, " R11 standby idle"}, 32'(standby), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(req_valid), 32'h0);
    chk("R1 standby", 32'(standby), 32'h1);
    chk("R1 oe", 32'(lad_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 9; v++) begin
      strap_id = VEC[v][6:3];
      drive_hdr(1'b0, 4'h0, VEC[v][46:43], VEC[v][42:39], VEC[v][38:7]);
      check_pulse($sformatf("vec%0d", v), VEC[v][2], VEC[v][1], VEC[v][0], VEC[v][38:7]);
    end

    // R2: start is the last low-frame nibble
    strap_id = 4'hA;
    drive_hdr(1'b1, 4'h5, 4'h0, 4'h4, 32'h00A80010);
    check_pulse("R2 last-low ok", 1'b1, 1'b0, 1'b1, 32'h00A80010);
    drive_hdr(1'b1, 4'h0, 4'h5, 4'h4, 32'h00A80010);
    check_pulse("R2 last-low bad", 1'b0, 1'b0, 1'b0, 32'h0);

    // R4 and R11: standby around a rejected cycle type
    @(negedge clk);
    frame_n = 1'b0; lad_in = 4'h0;
    @(negedge clk);
    chk("R11 busy after start", 32'(standby), 32'h0);
    frame_n = 1'b1; lad_in = 4'h1;
    @(negedge clk);
    chk("R4 standby after reject", 32'(standby), 32'h1);
    send_nibbles(32'h00A80000);
    chk("R4 no request", 32'(req_valid), 32'h0);

    // R9: abort mid-address, then a full new header
    @(negedge clk);
    frame_n = 1'b0; lad_in = 4'h0;
    @(negedge clk);
    frame_n = 1'b1; lad_in = 4'h6;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      lad_in = 4'h9;
    end
    @(negedge clk);
    frame_n = 1'b0; lad_in = 4'h0;
    @(negedge clk);
    chk("R9 R11 busy after restart", 32'(standby), 32'h0);
    frame_n = 1'b1; lad_in = 4'h4;
    send_nibbles(32'h0028BEEF);
    check_pulse("R9 restart", 1'b1, 1'b0, 1'b0, 32'h0028BEEF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule